// File: doc/BRIEF.md
# Lockable Translation Look-Aside Buffer

This block is a small fully associative translation buffer. It turns logical addresses from a 32-bit space into physical addresses. Each entry holds a page number, a frame number, an address-space tag, three permission bits, a valid flag and a lock flag. A lookup compares the request's page number and address-space tag against every entry at once. One cycle later the block returns one of three outcomes: a translated address, a miss event, or a protection fault event.

A real-time kernel or a refill engine loads entries through a write port. The caller can name the slot directly. It can also let the block choose a slot: one that already holds the same mapping, then a free one, then the least recently used unlocked one. Locked entries are never chosen as victims and survive flushes. Preloaded translations for a time-critical task therefore stay resident and that task never misses. After a miss, the requester repeats the same lookup once the refill has been written.

The page size is chosen at run time from five values between 256 and 4096 bytes. The larger the page, the fewer page-number bits take part in the compare.

Top module: `locked_xlat_tlb`

## Requirements
- R1: A request with `lk_valid` high produces `rsp_valid` high in the next cycle, together with exactly one outcome. On a permitted match, `rsp_ok` is 1 and `rsp_paddr` is the entry's frame field followed by the low 8 address bits.
- R2: `page_sel` values 0..4 select pages of 256, 512, 1024, 2048 and 4096 bytes, and values 5..7 act as 4. With select value s, the low s bits of the 24-bit page field (address bits 31:8) are left out of the compare. In the result, those s bits come from the logical address rather than from the frame field.
- R3: An entry matches only a request whose `lk_asid` equals the entry's address-space tag. The same page under another tag is a miss or hits a different entry.
- R4: Permission bit 0 allows reads, bit 1 allows writes and bit 2 allows execution. `lk_acc` is 0 for read, 1 for write, 2 for execute, and 3 is never permitted. A match whose access is not permitted raises `fault_irq` for one cycle with `rsp_ok` 0 and `rsp_paddr` 0.
- R5: A request that matches no entry raises `miss_irq` for one cycle with `rsp_ok` 0 and `rsp_paddr` 0. The same request repeated after a refill of that page returns `rsp_ok`.
- R6: A write with `wr_use_idx` high loads the slot `wr_idx`, even a locked one, and sets that slot's lock flag to `wr_lock`.
- R7: A write with `wr_use_idx` low picks its slot in this order: an unlocked valid entry with the same tag and page; otherwise the lowest-numbered free unlocked slot; otherwise the least recently used unlocked entry.
- R8: Every matching lookup and every accepted write marks its entry as most recently used.
- R9: Locked entries are never picked by writes without an index, and no flush clears them.
- R10: When a write without an index finds no unlocked slot, it is refused, the table is unchanged, and `wr_err` reads 1 from the next cycle. `wr_err` changes only on writes, and any accepted write returns it to 0.
- R11: `fl_en` clears every unlocked entry. With `fl_by_asid` high, it clears only the unlocked entries whose tag equals `fl_asid`.
- R12: Reset leaves all entries invalid and all outputs at 0, so the first lookup after reset is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 3 | Page size select, 0 = 256 B up to 4 = 4096 B |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Logical address |
| lk_asid | input | 8 | Address-space tag of the requester |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation found and permitted |
| miss_irq | output | 1 | No matching entry |
| fault_irq | output | 1 | Matching entry forbids the access |
| rsp_paddr | output | 32 | Physical address, 0 unless `rsp_ok` |
| wr_en | input | 1 | Entry write strobe |
| wr_use_idx | input | 1 | Use `wr_idx` instead of automatic slot choice |
| wr_idx | input | 4 | Explicit slot number |
| wr_asid | input | 8 | Tag of the new entry |
| wr_vpn | input | 24 | Page number in 256-byte units |
| wr_pfn | input | 24 | Frame number in 256-byte units |
| wr_perm | input | 3 | Permissions {exec, write, read} |
| wr_lock | input | 1 | Lock flag of the new entry |
| wr_err | output | 1 | Last write without index was refused |
| fl_en | input | 1 | Flush strobe |
| fl_by_asid | input | 1 | Restrict the flush to one tag |
| fl_asid | input | 8 | Tag to flush |

## Verification
The bench builds the block with its default parameters: 16 entries, 8-bit tags, 32-bit addresses and a 256-byte minimum page. At that size the table can be filled completely. This makes the all-locked refusal and a full least-recently-used ordering reachable in a few dozen writes. Page size is a run-time input, so all five sizes and the clamped selects are exercised on one build, against the same stored entries.

// File: rtl/locked_xlat_tlb.sv
module locked_xlat_tlb #(
  parameter int N_ENT   = 16,
  parameter int ASID_W  = 8,
  parameter int ADDR_W  = 32,
  parameter int MIN_OFF = 8,
  parameter int MAX_SEL = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  page_sel,
  input  logic                        lk_valid,
  input  logic [ADDR_W-1:0]           lk_addr,
  input  logic [ASID_W-1:0]           lk_asid,
  input  logic [1:0]                  lk_acc,
  output logic                        rsp_valid,
  output logic                        rsp_ok,
  output logic                        miss_irq,
  output logic                        fault_irq,
  output logic [ADDR_W-1:0]           rsp_paddr,
  input  logic                        wr_en,
  input  logic                        wr_use_idx,
  input  logic [$clog2(N_ENT)-1:0]    wr_idx,
  input  logic [ASID_W-1:0]           wr_asid,
  input  logic [ADDR_W-MIN_OFF-1:0]   wr_vpn,
  input  logic [ADDR_W-MIN_OFF-1:0]   wr_pfn,
  input  logic [2:0]                  wr_perm,
  input  logic                        wr_lock,
  output logic                        wr_err,
  input  logic                        fl_en,
  input  logic                        fl_by_asid,
  input  logic [ASID_W-1:0]           fl_asid
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int PN_W  = ADDR_W - MIN_OFF;

  logic [N_ENT-1:0]  v_q, lk_q;
  logic [ASID_W-1:0] asid_q [N_ENT];
  logic [PN_W-1:0]   vpn_q  [N_ENT];
  logic [PN_W-1:0]   pfn_q  [N_ENT];
  logic [2:0]        perm_q [N_ENT];
  logic [IDX_W-1:0]  age_q  [N_ENT];

  logic [2:0]      sel_eff;
  logic [PN_W-1:0] pmask, lk_pn, pa_pn;

  assign sel_eff = (page_sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : page_sel;
  assign pmask   = {PN_W{1'b1}} << sel_eff;
  assign lk_pn   = lk_addr[ADDR_W-1:MIN_OFF];

  logic             hit_any, dup_any, free_any, old_any;
  logic [IDX_W-1:0] hit_idx, dup_idx, free_idx, old_idx, old_age;

  always_comb begin
    hit_any  = 1'b0; hit_idx  = '0;
    dup_any  = 1'b0; dup_idx  = '0;
    free_any = 1'b0; free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (v_q[i] && asid_q[i] == lk_asid && ((vpn_q[i] ^ lk_pn) & pmask) == '0) begin
        hit_any = 1'b1; hit_idx = IDX_W'(i);
      end
      if (v_q[i] && !lk_q[i] && asid_q[i] == wr_asid && ((vpn_q[i] ^ wr_vpn) & pmask) == '0) begin
        dup_any = 1'b1; dup_idx = IDX_W'(i);
      end
      if (!v_q[i] && !lk_q[i]) begin
        free_any = 1'b1; free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    old_any = 1'b0; old_idx = '0; old_age = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (v_q[i] && !lk_q[i] && (!old_any || age_q[i] > old_age)) begin
        old_any = 1'b1; old_idx = IDX_W'(i); old_age = age_q[i];
      end
    end
  end

  logic             perm_ok, wr_go, t_en;
  logic [IDX_W-1:0] victim, wr_tgt, t_idx;

  always_comb begin
    case (lk_acc)
      2'd0:    perm_ok = perm_q[hit_idx][0];
      2'd1:    perm_ok = perm_q[hit_idx][1];
      2'd2:    perm_ok = perm_q[hit_idx][2];
      default: perm_ok = 1'b0;
    endcase
  end

  assign victim = dup_any ? dup_idx : (free_any ? free_idx : old_idx);
  assign wr_tgt = wr_use_idx ? wr_idx : victim;
  assign wr_go  = wr_en && (wr_use_idx || dup_any || free_any || old_any);
  assign t_en   = wr_go || (lk_valid && hit_any);
  assign t_idx  = wr_go ? wr_tgt : hit_idx;
  assign pa_pn  = (pfn_q[hit_idx] & pmask) | (lk_pn & ~pmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      lk_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      miss_irq  <= 1'b0;
      fault_irq <= 1'b0;
      rsp_paddr <= '0;
      wr_err    <= 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
        age_q[i]  <= IDX_W'(i);
        asid_q[i] <= '0;
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else begin
      rsp_valid <= lk_valid;
      rsp_ok    <= lk_valid && hit_any && perm_ok;
      miss_irq  <= lk_valid && !hit_any;
      fault_irq <= lk_valid && hit_any && !perm_ok;
      rsp_paddr <= (lk_valid && hit_any && perm_ok) ? {pa_pn, lk_addr[MIN_OFF-1:0]} : '0;
      if (wr_en) wr_err <= !wr_go;
      for (int i = 0; i < N_ENT; i++) begin
        if (fl_en && !lk_q[i] && (!fl_by_asid || asid_q[i] == fl_asid)) v_q[i] <= 1'b0;
        if (t_en) begin
          if (IDX_W'(i) == t_idx)            age_q[i] <= '0;
          else if (age_q[i] < age_q[t_idx])  age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (wr_go) begin
        v_q[wr_tgt]    <= 1'b1;
        lk_q[wr_tgt]   <= wr_lock;
        asid_q[wr_tgt] <= wr_asid;
        vpn_q[wr_tgt]  <= wr_vpn;
        pfn_q[wr_tgt]  <= wr_pfn;
        perm_q[wr_tgt] <= wr_perm;
      end
    end
  end
endmodule

// File: rtl/locked_xlat_tlb_chk.sv
module locked_xlat_tlb_chk #(
  parameter int N_ENT   = 16,
  parameter int ADDR_W  = 32,
  parameter int MIN_OFF = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              miss_irq,
  input logic              fault_irq,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              wr_en,
  input logic              wr_err,
  input logic              fl_en,
  input logic [N_ENT-1:0]  v_q,
  input logic [N_ENT-1:0]  lk_q
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, miss_irq, fault_irq}) == 1);
  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_ok || miss_irq || fault_irq));
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_ok || rsp_paddr[MIN_OFF-1:0] == $past(lk_addr[MIN_OFF-1:0])));
  assert_zero_addr_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ok |-> rsp_paddr == '0);
  assert_err_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_err));
  assert_locked_survive_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !wr_en) |=> ((v_q & $past(v_q & lk_q)) == $past(v_q & lk_q)));
endmodule

bind locked_xlat_tlb locked_xlat_tlb_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .MIN_OFF(MIN_OFF)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .miss_irq(miss_irq), .fault_irq(fault_irq),
  .rsp_paddr(rsp_paddr), .wr_en(wr_en), .wr_err(wr_err), .fl_en(fl_en),
  .v_q(v_q), .lk_q(lk_q)
);

// File: tb/locked_xlat_tlb_tb_top.sv
`timescale 1ns/1ps
module locked_xlat_tlb_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, lk_valid, rsp_valid, rsp_ok, miss_irq, fault_irq;
  logic [2:0]  page_sel, wr_perm;
  logic [31:0] lk_addr, rsp_paddr;
  logic [7:0]  lk_asid, wr_asid, fl_asid;
  logic [1:0]  lk_acc;
  logic        wr_en, wr_use_idx, wr_lock, wr_err, fl_en, fl_by_asid;
  logic [3:0]  wr_idx;
  logic [23:0] wr_vpn, wr_pfn;

  locked_xlat_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_asid(lk_asid), .lk_acc(lk_acc), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .miss_irq(miss_irq), .fault_irq(fault_irq), .rsp_paddr(rsp_paddr), .wr_en(wr_en),
    .wr_use_idx(wr_use_idx), .wr_idx(wr_idx), .wr_asid(wr_asid), .wr_vpn(wr_vpn),
    .wr_pfn(wr_pfn), .wr_perm(wr_perm), .wr_lock(wr_lock), .wr_err(wr_err),
    .fl_en(fl_en), .fl_by_asid(fl_by_asid), .fl_asid(fl_asid)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] r_code, r_pa;
  logic        r_v;

  localparam logic [1:0] OK = 2'd0, MISS = 2'd1, FLT = 2'd2;
  localparam int NV = 13;
  localparam logic [78:0] VEC [NV] = '{
    {3'd0, 8'h01, 2'd0, 32'h00010034, OK,   32'h000ABC34},
    {3'd0, 8'h02, 2'd2, 32'h00010034, OK,   32'h000DEF34},
    {3'd0, 8'h02, 2'd0, 32'h00010034, FLT,  32'h00000000},
    {3'd0, 8'h01, 2'd1, 32'h01234078, FLT,  32'h00000000},
    {3'd0, 8'h01, 2'd0, 32'h01234078, OK,   32'h05550078},
    {3'd0, 8'h03, 2'd0, 32'h01234078, MISS, 32'h00000000},
    {3'd0, 8'h01, 2'd0, 32'h00010134, MISS, 32'h00000000},
    {3'd0, 8'h01, 2'd3, 32'h000100FF, FLT,  32'h00000000},
    {3'd4, 8'h01, 2'd0, 32'h01234FA0, OK,   32'h05550FA0},
    {3'd2, 8'h01, 2'd0, 32'h01234278, OK,   32'h05550278},
    {3'd2, 8'h01, 2'd0, 32'h01234478, MISS, 32'h00000000},
    {3'd7, 8'h01, 2'd0, 32'h01234FA0, OK,   32'h05550FA0},
    {3'd1, 8'h01, 2'd1, 32'h00010134, OK,   32'h000ABD34}
  };
  string vtag [NV] = '{"R1", "R3", "R4", "R4", "R4", "R3", "R5", "R4", "R2", "R2", "R2", "R2", "R2"};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [2:0] ps, input logic [7:0] as, input logic [1:0] ac, input logic [31:0] ad);
    @(negedge clk);
    page_sel = ps; lk_asid = as; lk_acc = ac; lk_addr = ad; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    r_v    = rsp_valid;
    r_pa   = rsp_paddr;
    r_code = rsp_ok ? 32'd0 : miss_irq ? 32'd1 : fault_irq ? 32'd2 : 32'd3;
  endtask

  task automatic expect_lk(input string req, input logic [2:0] ps, input logic [7:0] as,
                           input logic [1:0] ac, input logic [31:0] ad, input logic [1:0] code,
                           input logic [31:0] pa);
    lookup(ps, as, ac, ad);
    chk(req, "valid", {31'd0, r_v}, 32'd1);
    chk(req, "outcome", r_code, {30'd0, code});
    chk(req, "paddr", r_pa, pa);
  endtask

  task automatic wr(input logic ui, input logic [3:0] ix, input logic [7:0] as, input logic [23:0] vp,
                    input logic [23:0] pf, input logic [2:0] pm, input logic lk);
    @(negedge clk);
    wr_en = 1'b1; wr_use_idx = ui; wr_idx = ix; wr_asid = as; wr_vpn = vp; wr_pfn = pf;
    wr_perm = pm; wr_lock = lk;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic flush(input logic by, input logic [7:0] as);
    @(negedge clk);
    fl_en = 1'b1; fl_by_asid = by; fl_asid = as;
    @(negedge clk);
    fl_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; page_sel = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; page_sel = 3'd0; lk_valid = 1'b0; lk_addr = '0; lk_asid = '0; lk_acc = '0;
    wr_en = 1'b0; wr_use_idx = 1'b0; wr_idx = '0; wr_asid = '0; wr_vpn = '0; wr_pfn = '0;
    wr_perm = '0; wr_lock = 1'b0; fl_en = 1'b0; fl_by_asid = 1'b0; fl_asid = '0;
    repeat (3) @(negedge clk);
    chk("R12", "rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "wr_err at reset", {31'd0, wr_err}, 32'd0);
    chk("R12", "flags at reset", {29'd0, rsp_ok, miss_irq, fault_irq}, 32'd0);
    rst_n = 1'b1;

    expect_lk("R12", 3'd0, 8'h01, 2'd0, 32'h00010034, MISS, 32'h0);
    wr(1'b1, 4'd0, 8'h01, 24'h000100, 24'h000ABC, 3'b011, 1'b0);
    expect_lk("R5", 3'd0, 8'h01, 2'd0, 32'h00010034, OK, 32'h000ABC34);
    wr(1'b1, 4'd1, 8'h02, 24'h000100, 24'h000DEF, 3'b100, 1'b0);
    wr(1'b1, 4'd2, 8'h01, 24'h012340, 24'h055500, 3'b001, 1'b0);

    for (int k = 0; k < NV; k++)
      expect_lk(vtag[k], VEC[k][78:76], VEC[k][75:68], VEC[k][67:66], VEC[k][65:34],
                VEC[k][33:32], VEC[k][31:0]);

    @(negedge clk);
    chk("R1", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

    flush(1'b1, 8'h02);
    expect_lk("R11", 3'd0, 8'h02, 2'd2, 32'h00010034, MISS, 32'h0);
    expect_lk("R11", 3'd0, 8'h01, 2'd0, 32'h00010034, OK, 32'h000ABC34);

    wr(1'b1, 4'd0, 8'h01, 24'h000100, 24'h000ABC, 3'b011, 1'b1);
    flush(1'b0, 8'h00);
    expect_lk("R9", 3'd0, 8'h01, 2'd0, 32'h00010034, OK, 32'h000ABC34);
    expect_lk("R11", 3'd0, 8'h01, 2'd0, 32'h01234078, MISS, 32'h0);

    do_reset();
    for (int i = 0; i < 16; i++)
      wr(1'b1, 4'(i), 8'h09, 24'h000200 + 24'(i), 24'h000300 + 24'(i), 3'b001, 1'b1);
    wr(1'b0, 4'd0, 8'h09, 24'h0002FF, 24'h0003FF, 3'b001, 1'b0);
    chk("R10", "wr_err when all locked", {31'd0, wr_err}, 32'd1);
    expect_lk("R10", 3'd0, 8'h09, 2'd0, 32'h0002FF00, MISS, 32'h0);
    expect_lk("R6", 3'd0, 8'h09, 2'd0, 32'h00020F44, OK, 32'h00030F44);
    wr(1'b1, 4'd5, 8'h09, 24'h0002F0, 24'h0003F0, 3'b001, 1'b0);
    chk("R10", "wr_err cleared", {31'd0, wr_err}, 32'd0);
    wr(1'b0, 4'd0, 8'h09, 24'h0002FF, 24'h0003FF, 3'b001, 1'b0);
    chk("R10", "wr_err after accepted", {31'd0, wr_err}, 32'd0);
    expect_lk("R9", 3'd0, 8'h09, 2'd0, 32'h0002FF12, OK, 32'h0003FF12);
    expect_lk("R7", 3'd0, 8'h09, 2'd0, 32'h0002F012, MISS, 32'h0);

    do_reset();
    for (int i = 0; i < 16; i++)
      wr(1'b0, 4'd0, 8'h05, 24'(i), 24'h000100 + 24'(i), 3'b001, i == 0);
    wr(1'b0, 4'd0, 8'h05, 24'h000050, 24'h000150, 3'b001, 1'b0);
    wr(1'b0, 4'd0, 8'h05, 24'h000051, 24'h000151, 3'b001, 1'b0);
    expect_lk("R8", 3'd0, 8'h05, 2'd0, 32'h00000310, OK, 32'h00010310);
    wr(1'b0, 4'd0, 8'h05, 24'h000052, 24'h000152, 3'b001, 1'b0);
    expect_lk("R9", 3'd0, 8'h05, 2'd0, 32'h00000110, MISS, 32'h0);
    expect_lk("R8", 3'd0, 8'h05, 2'd0, 32'h00000210, MISS, 32'h0);
    expect_lk("R8", 3'd0, 8'h05, 2'd0, 32'h00000410, MISS, 32'h0);
    expect_lk("R8", 3'd0, 8'h05, 2'd0, 32'h00000310, OK, 32'h00010310);
    expect_lk("R7", 3'd0, 8'h05, 2'd0, 32'h00000510, OK, 32'h00010510);
    expect_lk("R9", 3'd0, 8'h05, 2'd0, 32'h00000010, OK, 32'h00010010);
    expect_lk("R7", 3'd0, 8'h05, 2'd0, 32'h00005210, OK, 32'h00015210);
    wr(1'b0, 4'd0, 8'h05, 24'h000005, 24'h000777, 3'b001, 1'b0);
    expect_lk("R7", 3'd0, 8'h05, 2'd0, 32'h00000610, OK, 32'h00010610);
    expect_lk("R7", 3'd0, 8'h05, 2'd0, 32'h00000510, OK, 32'h00077710);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule